// File: doc/BRIEF.md
# Host Package Parser and Card Write Path

This block sits between a host link that delivers 16-bit words and a byte-wide backplane write bus feeding a rack of waveform cards. It watches the word stream for framed packages. A waveform package names a channel and a memory segment, carries its samples as a run of payload words, and is closed by an end marker. The block holds the payload in a local word buffer until the end marker shows that the declared length matches the received count. Only then does it stream the samples out, one byte per cycle, toward the addressed card, the channel's half of the memory word and the segment's base address.

A command package carries the sequencer program. Its words are written straight into a program buffer as they arrive. The end marker then confirms or rejects the package with a one-cycle status pulse. While a waveform package is being streamed out, the block drops its ready output, and words offered during that time are not taken.

The channel number picks a card (channel / 2) and the upper or lower half of that card's memory word (channel % 2). The write address starts at segment × 8192. Payload bytes are grouped into 9-byte packets. Each packet fills two 36-bit memory words, so the address steps by two at every packet boundary.

Top module: `hpp_host_parser`

## Requirements
- R1: During reset and immediately after it, in_ready is 1 and wr_valid, prog_we, pkt_ok and pkt_err are all 0.
- R2: While no package is open, any word other than the waveform start code 0xA5D1 or the command start code 0xA5C3 is ignored and produces no output.
- R3: A waveform package is the start code 0xA5D1, then a length word L (the number of payload words), a channel word, a segment word (low 4 bits used), L payload words, and the end code 0xA5E7. If the package is accepted, pkt_ok is high for exactly one cycle, the cycle after the end word is taken.
- R4: An accepted waveform package with L > 0 produces 2L byte transfers on consecutive cycles. The first transfer comes the cycle after pkt_ok. Each payload word is sent high byte first, in arrival order.
- R5: For payload byte b, wr_card = channel/2, wr_half = channel%2, wr_pos = b mod 9, and wr_addr = segment×8192 + 2×(b div 9).
- R6: in_ready is 0 for exactly 2L cycles, starting with the pkt_ok cycle of an accepted waveform package with L > 0. It returns to 1 in the cycle that shows the last byte.
- R7: A command package is 0xA5C3, one reserved word, a length word L, L command words, and 0xA5E7. Command word i appears on prog_we/prog_addr=i/prog_data one cycle after it is taken. pkt_ok follows the end word by one cycle.
- R8: If the count of words received before the end code differs from L, pkt_err pulses for one cycle (the cycle after the end word). There is then no pkt_ok and no byte transfer.
- R9: A channel word of 24 or more makes the waveform package fail with pkt_err, and no byte is sent.
- R10: A waveform length above 64, or a command length above 32, fails with pkt_err. Command words with index 32 or more are never written.
- R11: A word offered while in_ready is 0 is not taken and has no effect on any output.
- R12: A waveform package with L = 0 and no payload gives pkt_ok and no byte transfer, and in_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host word present |
| in_word | input | 16 | Host word |
| in_ready | output | 1 | Word is taken when in_valid and in_ready |
| wr_valid | output | 1 | Byte transfer present on the card bus |
| wr_card | output | 4 | Addressed card |
| wr_half | output | 1 | Upper (1) or lower (0) half of the memory word |
| wr_addr | output | 17 | Memory word address of the current packet |
| wr_pos | output | 4 | Byte position 0..8 inside the 9-byte packet |
| wr_byte | output | 8 | Payload byte |
| prog_we | output | 1 | Program buffer write strobe |
| prog_addr | output | 5 | Program buffer index |
| prog_data | output | 16 | Command word |
| pkt_ok | output | 1 | One-cycle pulse: package accepted |
| pkt_err | output | 1 | One-cycle pulse: package rejected |

## Verification
Each result has a fixed distance from the word that causes it. A program write and the ok/err pulse appear one cycle after the word is taken. Byte b of an accepted waveform package appears b+2 cycles after its end word. The ready output is low over exactly the window that ends as the last byte shows. The bench logs every expectation under the cycle number at which it falls due. It then compares every output against that log at each falling edge, so a result that arrives one cycle early or late counts as a mismatch. Words that the bench offers while the model predicts a stall are left out of the model, so any effect they have on the outputs shows up as a mismatch.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  localparam logic [15:0] HDR_DATA = 16'hA5D1;
  localparam logic [15:0] HDR_CMD  = 16'hA5C3;
  localparam logic [15:0] HDR_END  = 16'hA5E7;

  typedef enum logic [2:0] {
    PS_IDLE, PS_DLEN, PS_DCH, PS_DSEG, PS_DPAY, PS_CRSV, PS_CLEN, PS_CPAY
  } pstate_t;
endpackage

// File: rtl/hpp_frame_ctrl.sv
module hpp_frame_ctrl
  import hpp_pkg::*;
#(
  parameter int NUM_CH     = 24,
  parameter int CH_W       = 5,
  parameter int SEG_W      = 4,
  parameter int BUF_WORDS  = 64,
  parameter int BUF_AW     = 6,
  parameter int PROG_DEPTH = 32,
  parameter int PROG_AW    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_fire,
  input  logic [15:0]        in_word,
  output logic               buf_we,
  output logic [BUF_AW-1:0]  buf_waddr,
  output logic               prog_we,
  output logic [PROG_AW-1:0] prog_addr,
  output logic [15:0]        prog_data,
  output logic               pkt_ok,
  output logic               pkt_err,
  output logic               drain_start,
  output logic [BUF_AW:0]    drain_len,
  output logic [CH_W-1:0]    ch_q,
  output logic [SEG_W-1:0]   seg_q
);
  localparam logic [15:0] BUF_LIM  = 16'(BUF_WORDS);
  localparam logic [15:0] PROG_LIM = 16'(PROG_DEPTH);
  localparam logic [15:0] CH_LIM   = 16'(NUM_CH);

  pstate_t             state_q, state_d;
  logic [15:0]         len_q, len_d;
  logic [15:0]         cnt_q, cnt_d;
  logic [CH_W-1:0]     ch_d;
  logic                chok_q, chok_d;
  logic [SEG_W-1:0]    seg_d;
  logic                prog_we_d, pkt_ok_d, pkt_err_d, drain_start_d;
  logic [PROG_AW-1:0]  prog_addr_d;
  logic [15:0]         prog_data_d;
  logic [BUF_AW:0]     drain_len_d;
  logic                is_end, d_err, c_err;
  logic [15:0]         cnt_inc;

  assign is_end    = (in_word == HDR_END);
  assign d_err     = (cnt_q != len_q) | (len_q > BUF_LIM) | ~chok_q;
  assign c_err     = (cnt_q != len_q) | (len_q > PROG_LIM);
  assign cnt_inc   = (cnt_q == 16'hFFFF) ? cnt_q : cnt_q + 16'd1;
  assign buf_waddr = cnt_q[BUF_AW-1:0];

  // next-state process
  always_comb begin
    state_d       = state_q;
    len_d         = len_q;
    cnt_d         = cnt_q;
    ch_d          = ch_q;
    chok_d        = chok_q;
    seg_d         = seg_q;
    prog_we_d     = 1'b0;
    prog_addr_d   = prog_addr;
    prog_data_d   = prog_data;
    pkt_ok_d      = 1'b0;
    pkt_err_d     = 1'b0;
    drain_start_d = 1'b0;
    drain_len_d   = drain_len;
    buf_we        = 1'b0;
    if (in_fire) begin
      unique case (state_q)
        PS_IDLE: begin
          cnt_d = '0;
          if (in_word == HDR_DATA)     state_d = PS_DLEN;
          else if (in_word == HDR_CMD) state_d = PS_CRSV;
        end
        PS_DLEN: begin
          len_d   = in_word;
          state_d = PS_DCH;
        end
        PS_DCH: begin
          ch_d    = in_word[CH_W-1:0];
          chok_d  = (in_word < CH_LIM);
          state_d = PS_DSEG;
        end
        PS_DSEG: begin
          seg_d   = in_word[SEG_W-1:0];
          state_d = PS_DPAY;
        end
        PS_DPAY: begin
          if (is_end) begin
            pkt_ok_d      = ~d_err;
            pkt_err_d     = d_err;
            drain_start_d = ~d_err & (len_q != 16'd0);
            drain_len_d   = len_q[BUF_AW:0];
            state_d       = PS_IDLE;
          end else begin
            buf_we = (cnt_q < BUF_LIM);
            cnt_d  = cnt_inc;
          end
        end
        PS_CRSV: state_d = PS_CLEN;
        PS_CLEN: begin
          len_d   = in_word;
          state_d = PS_CPAY;
        end
        PS_CPAY: begin
          if (is_end) begin
            pkt_ok_d  = ~c_err;
            pkt_err_d = c_err;
            state_d   = PS_IDLE;
          end else begin
            prog_we_d   = (cnt_q < PROG_LIM);
            prog_addr_d = cnt_q[PROG_AW-1:0];
            prog_data_d = in_word;
            cnt_d       = cnt_inc;
          end
        end
        default: state_d = PS_IDLE;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PS_IDLE;
      len_q       <= '0;
      cnt_q       <= '0;
      ch_q        <= '0;
      chok_q      <= 1'b0;
      seg_q       <= '0;
      prog_we     <= 1'b0;
      prog_addr   <= '0;
      prog_data   <= '0;
      pkt_ok      <= 1'b0;
      pkt_err     <= 1'b0;
      drain_start <= 1'b0;
      drain_len   <= '0;
    end else begin
      state_q     <= state_d;
      len_q       <= len_d;
      cnt_q       <= cnt_d;
      ch_q        <= ch_d;
      chok_q      <= chok_d;
      seg_q       <= seg_d;
      prog_we     <= prog_we_d;
      prog_addr   <= prog_addr_d;
      prog_data   <= prog_data_d;
      pkt_ok      <= pkt_ok_d;
      pkt_err     <= pkt_err_d;
      drain_start <= drain_start_d;
      drain_len   <= drain_len_d;
    end
  end
endmodule

// File: rtl/hpp_word_buf.sv
module hpp_word_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);
  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hpp_byte_drain.sv
module hpp_byte_drain #(
  parameter int CH_W   = 5,
  parameter int SEG_W  = 4,
  parameter int SEG_SH = 13,
  parameter int BUF_AW = 6,
  localparam int CARD_W = CH_W - 1,
  localparam int ADDR_W = SEG_W + SEG_SH,
  localparam int IDX_W  = BUF_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUF_AW:0]   len,
  input  logic [CH_W-1:0]   ch,
  input  logic [SEG_W-1:0]  seg,
  output logic [BUF_AW-1:0] rd_addr,
  input  logic [15:0]       rd_word,
  output logic              active,
  output logic              wr_valid,
  output logic [CARD_W-1:0] wr_card,
  output logic              wr_half,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [3:0]        wr_pos,
  output logic [7:0]        wr_byte
);
  logic [IDX_W-1:0]  idx_q, idx_d, last_q, last_d, cur_idx;
  logic [3:0]        npos_q, npos_d;
  logic [ADDR_W-1:0] naddr_q, naddr_d, base;
  logic              active_d, emit;
  logic [IDX_W:0]    twice_m1;
  logic              wr_valid_d, wr_half_d;
  logic [CARD_W-1:0] wr_card_d;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [3:0]        wr_pos_d;
  logic [7:0]        wr_byte_d;

  assign base     = {seg, {SEG_SH{1'b0}}};
  assign twice_m1 = {len, 1'b0} - (IDX_W + 1)'(1);
  assign emit     = start | active;
  assign cur_idx  = start ? '0 : idx_q;
  assign rd_addr  = cur_idx[IDX_W-1:1];

  always_comb begin
    idx_d      = idx_q;
    last_d     = last_q;
    npos_d     = npos_q;
    naddr_d    = naddr_q;
    active_d   = active;
    wr_valid_d = emit;
    wr_card_d  = wr_card;
    wr_half_d  = wr_half;
    wr_addr_d  = wr_addr;
    wr_pos_d   = wr_pos;
    wr_byte_d  = wr_byte;
    if (emit) begin
      wr_card_d = ch[CH_W-1:1];
      wr_half_d = ch[0];
      wr_addr_d = start ? base : naddr_q;
      wr_pos_d  = start ? 4'd0 : npos_q;
      wr_byte_d = cur_idx[0] ? rd_word[7:0] : rd_word[15:8];
    end
    if (start) begin
      active_d = 1'b1;
      idx_d    = IDX_W'(1);
      last_d   = twice_m1[IDX_W-1:0];
      npos_d   = 4'd1;
      naddr_d  = base;
    end else if (active) begin
      active_d = (idx_q != last_q);
      idx_d    = idx_q + IDX_W'(1);
      if (npos_q == 4'd8) begin
        npos_d  = 4'd0;
        naddr_d = naddr_q + ADDR_W'(2);
      end else begin
        npos_d  = npos_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      last_q   <= '0;
      npos_q   <= '0;
      naddr_q  <= '0;
      active   <= 1'b0;
      wr_valid <= 1'b0;
      wr_card  <= '0;
      wr_half  <= 1'b0;
      wr_addr  <= '0;
      wr_pos   <= '0;
      wr_byte  <= '0;
    end else begin
      idx_q    <= idx_d;
      last_q   <= last_d;
      npos_q   <= npos_d;
      naddr_q  <= naddr_d;
      active   <= active_d;
      wr_valid <= wr_valid_d;
      wr_card  <= wr_card_d;
      wr_half  <= wr_half_d;
      wr_addr  <= wr_addr_d;
      wr_pos   <= wr_pos_d;
      wr_byte  <= wr_byte_d;
    end
  end
endmodule

// File: rtl/hpp_host_parser.sv
module hpp_host_parser #(
  parameter int NUM_CARDS  = 12,
  parameter int BUF_WORDS  = 64,
  parameter int PROG_DEPTH = 32,
  parameter int NUM_SEGS   = 16,
  parameter int SEG_WORDS  = 8192,
  localparam int CARD_W  = $clog2(NUM_CARDS),
  localparam int CH_W    = CARD_W + 1,
  localparam int NUM_CH  = 2 * NUM_CARDS,
  localparam int BUF_AW  = $clog2(BUF_WORDS),
  localparam int PROG_AW = $clog2(PROG_DEPTH),
  localparam int SEG_W   = $clog2(NUM_SEGS),
  localparam int SEG_SH  = $clog2(SEG_WORDS),
  localparam int ADDR_W  = SEG_W + SEG_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [15:0]        in_word,
  output logic               in_ready,
  output logic               wr_valid,
  output logic [CARD_W-1:0]  wr_card,
  output logic               wr_half,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [3:0]         wr_pos,
  output logic [7:0]         wr_byte,
  output logic               prog_we,
  output logic [PROG_AW-1:0] prog_addr,
  output logic [15:0]        prog_data,
  output logic               pkt_ok,
  output logic               pkt_err
);
  logic              rst_q1, rst_q2;
  logic              in_fire, buf_we, drain_start, drain_active;
  logic [BUF_AW-1:0] buf_waddr, buf_raddr;
  logic [15:0]       buf_rdata;
  logic [BUF_AW:0]   drain_len;
  logic [CH_W-1:0]   ch_q;
  logic [SEG_W-1:0]  seg_q;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  assign in_ready = ~(drain_start | drain_active);
  assign in_fire  = in_valid & in_ready;

  hpp_frame_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .SEG_W(SEG_W), .BUF_WORDS(BUF_WORDS),
    .BUF_AW(BUF_AW), .PROG_DEPTH(PROG_DEPTH), .PROG_AW(PROG_AW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_q2), .in_fire(in_fire), .in_word(in_word),
    .buf_we(buf_we), .buf_waddr(buf_waddr),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .pkt_ok(pkt_ok), .pkt_err(pkt_err),
    .drain_start(drain_start), .drain_len(drain_len),
    .ch_q(ch_q), .seg_q(seg_q)
  );

  hpp_word_buf #(.DEPTH(BUF_WORDS), .AW(BUF_AW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(in_word),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  hpp_byte_drain #(
    .CH_W(CH_W), .SEG_W(SEG_W), .SEG_SH(SEG_SH), .BUF_AW(BUF_AW)
  ) u_drain (
    .clk(clk), .rst_n(rst_q2), .start(drain_start), .len(drain_len),
    .ch(ch_q), .seg(seg_q), .rd_addr(buf_raddr), .rd_word(buf_rdata),
    .active(drain_active), .wr_valid(wr_valid), .wr_card(wr_card),
    .wr_half(wr_half), .wr_addr(wr_addr), .wr_pos(wr_pos), .wr_byte(wr_byte)
  );
endmodule

// File: rtl/hpp_host_parser_chk.sv
module hpp_host_parser_chk #(
  parameter int NUM_CARDS = 12,
  parameter int CARD_W    = 4,
  parameter int ADDR_W    = 17
) (
  input logic              clk,
  input logic              rst_i,
  input logic              in_valid,
  input logic              in_ready,
  input logic              wr_valid,
  input logic [CARD_W-1:0] wr_card,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [3:0]        wr_pos,
  input logic              prog_we,
  input logic              pkt_ok,
  input logic              pkt_err
);
  assert_pos_range_R5: assert property (@(posedge clk) disable iff (!rst_i)
    wr_valid |-> (wr_pos < 4'd9));

  assert_pos_step_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_valid && $past(wr_valid)) |->
      (wr_pos == (($past(wr_pos) == 4'd8) ? 4'd0 : $past(wr_pos) + 4'd1)));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_valid && $past(wr_valid)) |->
      (wr_addr == (($past(wr_pos) == 4'd8) ? $past(wr_addr) + ADDR_W'(2) : $past(wr_addr))));

  assert_card_range_R9: assert property (@(posedge clk) disable iff (!rst_i)
    wr_valid |-> (32'(wr_card) < NUM_CARDS));

  assert_outcome_excl_R8: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({pkt_ok, pkt_err}));

  assert_prog_after_take_R7: assert property (@(posedge clk) disable iff (!rst_i)
    prog_we |-> $past(in_valid && in_ready));

  assert_drain_after_ok_R4: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(wr_valid) |-> (!in_ready && $past(pkt_ok)));
endmodule

bind hpp_host_parser hpp_host_parser_chk #(
  .NUM_CARDS(NUM_CARDS), .CARD_W(CARD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_i(rst_q2), .in_valid(in_valid), .in_ready(in_ready),
  .wr_valid(wr_valid), .wr_card(wr_card), .wr_addr(wr_addr), .wr_pos(wr_pos),
  .prog_we(prog_we), .pkt_ok(pkt_ok), .pkt_err(pkt_err)
);

// File: tb/hpp_host_parser_tb.sv
module hpp_host_parser_tb;
  localparam logic [15:0] C_DATA = 16'hA5D1;
  localparam logic [15:0] C_CMD  = 16'hA5C3;
  localparam logic [15:0] C_END  = 16'hA5E7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = 16'h0;
  logic        in_ready, wr_valid, wr_half, prog_we, pkt_ok, pkt_err;
  logic [3:0]  wr_card, wr_pos;
  logic [16:0] wr_addr;
  logic [7:0]  wr_byte;
  logic [4:0]  prog_addr;
  logic [15:0] prog_data;

  hpp_host_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .wr_valid(wr_valid), .wr_card(wr_card),
    .wr_half(wr_half), .wr_addr(wr_addr), .wr_pos(wr_pos), .wr_byte(wr_byte),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .pkt_ok(pkt_ok), .pkt_err(pkt_err)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0;
  int    fails  = 0;
  string scen   = "R1";

  // expectations indexed by the cycle in which they are due
  logic [33:0] exp_wr [int];
  logic [20:0] exp_pg [int];
  bit          exp_ok [int];
  bit          exp_er [int];
  bit          busy   [int];

  // behavioural package model
  int          ms = 0;
  int          m_len, m_cnt, m_ch, m_seg;
  logic [15:0] m_buf [$];

  task automatic chk(input bit good, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s (scenario %s) cycle %0d: actual %h expected %h",
               req, scen, cyc, act, expv);
    end
  endtask

  task automatic model(input logic [15:0] w, input int e);
    bit bad;
    case (ms)
      0: begin
        m_cnt = 0;
        m_buf.delete();
        if (w == C_DATA) ms = 1;
        else if (w == C_CMD) ms = 5;
      end
      1: begin m_len = int'(w); ms = 2; end
      2: begin m_ch = int'(w); ms = 3; end
      3: begin m_seg = int'(w) % 16; ms = 4; end
      4: begin
        if (w == C_END) begin
          bad = (m_cnt != m_len) || (m_len > 64) || (m_ch >= 24);
          if (bad) exp_er[e] = 1'b1;
          else begin
            exp_ok[e] = 1'b1;
            for (int b = 0; b < 2 * m_len; b++) begin
              logic [15:0] wd;
              logic [7:0]  by;
              int          ad;
              wd = m_buf[b / 2];
              by = (b % 2 == 0) ? wd[15:8] : wd[7:0];
              ad = m_seg * 8192 + 2 * (b / 9);
              exp_wr[e + 1 + b] = {4'(m_ch / 2), 1'(m_ch % 2), 17'(ad), 4'(b % 9), by};
              busy[e + b] = 1'b1;
            end
          end
          ms = 0;
        end else begin
          m_buf.push_back(w);
          m_cnt++;
        end
      end
      5: ms = 6;
      6: begin m_len = int'(w); ms = 7; end
      default: begin
        if (w == C_END) begin
          bad = (m_cnt != m_len) || (m_len > 32);
          if (bad) exp_er[e] = 1'b1; else exp_ok[e] = 1'b1;
          ms = 0;
        end else begin
          if (m_cnt < 32) exp_pg[e] = {5'(m_cnt), w};
          m_cnt++;
        end
      end
    endcase
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    if (!busy.exists(cyc)) model(w, cyc + 1);  // words during a stall: R11
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic data_pkg(input int len, input int nwords, input int ch,
                          input int seg, input int seed);
    send(C_DATA); send(16'(len)); send(16'(ch)); send(16'(seg));
    for (int i = 0; i < nwords; i++) send(16'((seed + i * 16'h1357) ^ (i << 9)));
    send(C_END);
  endtask

  task automatic cmd_pkg(input int len, input int nwords);
    send(C_CMD); send(16'h0000); send(16'(len));
    for (int i = 0; i < nwords; i++) send(16'(16'h2000 + i * 3));
    send(C_END);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cyc > 0) begin
      chk(in_ready === !busy.exists(cyc), "R6", 64'(in_ready), 64'(!busy.exists(cyc)));
      if (exp_wr.exists(cyc))
        chk(wr_valid === 1'b1 && {wr_card, wr_half, wr_addr, wr_pos, wr_byte} === exp_wr[cyc],
            "R5", {29'(wr_valid), wr_card, wr_half, wr_addr, wr_pos, wr_byte},
            64'(exp_wr[cyc]) | 64'h4_0000_0000);
      else
        chk(wr_valid === 1'b0, "R4", 64'(wr_valid), 64'd0);
      if (exp_pg.exists(cyc))
        chk(prog_we === 1'b1 && {prog_addr, prog_data} === exp_pg[cyc], "R7",
            {42'(prog_we), prog_addr, prog_data}, 64'(exp_pg[cyc]) | 64'h20_0000);
      else
        chk(prog_we === 1'b0, "R7", 64'(prog_we), 64'd0);
      chk(pkt_ok === exp_ok.exists(cyc), "R3", 64'(pkt_ok), 64'(exp_ok.exists(cyc)));
      chk(pkt_err === exp_er.exists(cyc), "R8", 64'(pkt_err), 64'(exp_er.exists(cyc)));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset values while rst_n is low and just after release
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && wr_valid === 1'b0 && prog_we === 1'b0 &&
        pkt_ok === 1'b0 && pkt_err === 1'b0, "R1",
        {in_ready, wr_valid, prog_we, pkt_ok, pkt_err}, 64'b10000);
    rst_n = 1'b1;
    idle(4);

    scen = "R2";   // stray words outside a package
    send(16'h1234); send(C_END); send(16'hFFFF); send(16'h0000);
    idle(3);

    scen = "R4";   // 5 words, channel 7, segment 3: crosses a packet boundary
    data_pkg(5, 5, 7, 3, 16'hB00F);
    scen = "R11";  // words offered during the drain stall are dropped
    send(C_CMD); send(16'h0000); send(16'd1); send(16'h7777); send(C_END);
    idle(14);

    scen = "R7";   // command package of four words
    cmd_pkg(4, 4);
    idle(3);

    scen = "R8";   // declared 3, sent 2
    data_pkg(3, 2, 4, 1, 16'h4444);
    idle(4);
    cmd_pkg(5, 6);
    idle(3);

    scen = "R9";   // channel out of range
    data_pkg(2, 2, 24, 0, 16'h0102);
    idle(6);

    scen = "R10";  // command over program capacity, waveform over buffer capacity
    cmd_pkg(40, 40);
    idle(3);
    data_pkg(65, 65, 2, 2, 16'h9A9A);
    idle(6);

    scen = "R12";  // empty waveform package
    data_pkg(0, 0, 5, 6, 16'h0);
    idle(4);

    scen = "R5";   // top channel and segment, several packets
    data_pkg(20, 20, 23, 15, 16'hC3A5);
    idle(48);
    data_pkg(64, 64, 0, 0, 16'h5A01);
    idle(140);

    finish_run();
  end
endmodule